// File: doc/BRIEF.md
# GF(2^233) Squarer with Trinomial Fast Reduction

This block squares an element of the binary field GF(2^233), which is stored in polynomial basis, and returns the reduced 233-bit result. Squaring a polynomial over GF(2) needs no partial products. Each input bit i moves to bit position 2i, and a zero sits between neighbouring bits. This gives a 465-bit polynomial. A fixed-trinomial fold then brings the value back to 233 bits. The fold is made of wiring and XOR gates only, and it finishes within one clock cycle.

The same reduction path can also take a 465-bit unreduced product from outside. A separate multiplier can therefore share the reducer with the squarer. A mode input chooses which source feeds the fold. A clock enable loads the result register, and a valid flag shows on the following cycle that a new result is present.

Top module: `gf_sq_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled cycle, `res_out` is all zeros and `vld_out` is 0.
- R2: With `mode`=0 (square), a cycle with `en`=1 leaves `res_out` = `a_in`^2 mod (x^233 + x^74 + 1) after the next rising edge. Bit 2i of the unreduced square is `a_in` bit i, and every odd bit is 0.
- R3: With `mode`=1 (reduce), a cycle with `en`=1 leaves `res_out` = `wide_in` mod (x^233 + x^74 + 1) after the next rising edge. Bit j of `wide_in` is the coefficient of x^j.
- R4: In a cycle with `en`=0, `res_out` keeps its previous value, whatever the other inputs are.
- R5: `vld_out` is 1 in the cycle after a cycle with `en`=1, and 0 in the cycle after a cycle with `en`=0.
- R6: The square of `a_in` equals the field product of `a_in` with itself. Squaring is linear: sq(a^b) = sq(a) ^ sq(b).
- R7: In mode 0, `wide_in` has no effect on the result. In mode 1, `a_in` has no effect on the result.
- R8: In mode 1, a `wide_in` with bits 464..233 all zero comes out unchanged. The terms of degree 233 and above that the first fold produces are folded a second time, so every result has degree below 233.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Load enable for the result register |
| mode | input | 1 | 0 = square `a_in`, 1 = reduce `wide_in` |
| a_in | input | 233 | Field element to square |
| wide_in | input | 465 | Unreduced polynomial, for example a multiplier product |
| res_out | output | 233 | Registered reduced result |
| vld_out | output | 1 | High in the cycle after a load |

## Verification
The bound assertions check the cycle-level rules on every clock. `vld_out` follows `en` by one cycle, and the result holds when `en` is low. A short `wide_in` passes through unchanged, and squaring 0 or 1 returns 0 or 1. Only the bench can show the full arithmetic: random and corner operands are compared with a long division by the trinomial and with a shift-and-add product of the operand with itself. The corner operands include x^232, all-ones and x^464. The bench also shows linearity, and that the unselected input is ignored.

// File: rtl/gf_sq_pkg.sv
package gf_sq_pkg;
  localparam int unsigned FIELD_M = 233;
  localparam int unsigned TRI_K   = 74;

  typedef enum logic {
    SQ_MODE_SQUARE = 1'b0,
    SQ_MODE_REDUCE = 1'b1
  } sq_mode_e;
endpackage

// File: rtl/gf_rst_sync.sv
module gf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gf_interleave.sv
module gf_interleave #(
  parameter int unsigned M = 233
) (
  input  logic [M-1:0]   a,
  output logic [2*M-2:0] sq
);
  for (genvar i = 0; i < M; i++) begin : g_even
    assign sq[2*i] = a[i];
  end
  for (genvar i = 0; i < M-1; i++) begin : g_odd
    assign sq[2*i+1] = 1'b0;
  end
endmodule

// File: rtl/gf_fold.sv
module gf_fold #(
  parameter int unsigned IN_W  = 465,
  parameter int unsigned M     = 233,
  parameter int unsigned K     = 74,
  parameter int unsigned OUT_W = 306
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned HW = IN_W - M;

  logic [OUT_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(M); i++) begin
      acc[i] = din[i];
    end
    for (int j = 0; j < int'(HW); j++) begin
      acc[j]   = acc[j]   ^ din[M+j];
      acc[j+K] = acc[j+K] ^ din[M+j];
    end
  end

  assign dout = acc;
endmodule

// File: rtl/gf_sq_top.sv
module gf_sq_top
  import gf_sq_pkg::*;
#(
  parameter int unsigned M = FIELD_M,
  parameter int unsigned K = TRI_K
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           mode,
  input  logic [M-1:0]   a_in,
  input  logic [2*M-2:0] wide_in,
  output logic [M-1:0]   res_out,
  output logic           vld_out
);
  localparam int unsigned W   = 2*M - 1;
  localparam int unsigned H1  = W - M;
  localparam int unsigned F1W = (H1 + K > M) ? (H1 + K) : M;

  logic           rst_n_s;
  logic [W-1:0]   sq_wide;
  logic [W-1:0]   fold_src;
  logic [F1W-1:0] fold1;
  logic [M-1:0]   fold2;
  logic [M-1:0]   res_d, res_q;
  logic           vld_d, vld_q;
  sq_mode_e       mode_e;

  gf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  gf_interleave #(.M(M)) u_ilv (
    .a(a_in), .sq(sq_wide)
  );

  assign mode_e   = sq_mode_e'(mode);
  assign fold_src = (mode_e == SQ_MODE_REDUCE) ? wide_in : sq_wide;

  gf_fold #(.IN_W(W), .M(M), .K(K), .OUT_W(F1W)) u_fold1 (
    .din(fold_src), .dout(fold1)
  );

  gf_fold #(.IN_W(F1W), .M(M), .K(K), .OUT_W(M)) u_fold2 (
    .din(fold1), .dout(fold2)
  );

  always_comb begin
    res_d = res_q;
    if (en) res_d = fold2;
    vld_d = en;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign res_out = res_q;
  assign vld_out = vld_q;
endmodule

// File: rtl/gf_sq_chk.sv
module gf_sq_chk #(
  parameter int unsigned M = 233
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           mode,
  input logic [M-1:0]   a_in,
  input logic [2*M-2:0] wide_in,
  input logic [M-1:0]   res_out,
  input logic           vld_out
);
  p_vld_follows_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_out);

  p_vld_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_out);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(res_out));

  p_short_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && (wide_in[2*M-2:M] == '0)) |=> (res_out == $past(wide_in[M-1:0])));

  p_square_zero_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && (a_in[M-1:1] == '0)) |=> (res_out == $past(a_in)));
endmodule

bind gf_sq_top gf_sq_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .a_in(a_in),
  .wide_in(wide_in), .res_out(res_out), .vld_out(vld_out)
);

// File: tb/gf_sq_top_test.sv
module gf_sq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int FM = 233;
  localparam int FK = 74;
  localparam int FW = 2*FM - 1;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic          mode;
  logic [FM-1:0] a_in;
  logic [FW-1:0] wide_in;
  logic [FM-1:0] res_out;
  logic          vld_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  gf_sq_top uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .a_in(a_in),
    .wide_in(wide_in), .res_out(res_out), .vld_out(vld_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FM-1:0] ref_reduce(input logic [FW-1:0] w);
    logic [FW-1:0] c;
    c = w;
    for (int i = FW-1; i >= FM; i--) begin
      if (c[i]) begin
        c[i] = 1'b0;
        c[i-FM] = c[i-FM] ^ 1'b1;
        c[i-FM+FK] = c[i-FM+FK] ^ 1'b1;
      end
    end
    return c[FM-1:0];
  endfunction

  function automatic logic [FW-1:0] ref_spread(input logic [FM-1:0] a);
    logic [FW-1:0] s;
    s = '0;
    for (int i = 0; i < FM; i++) s[2*i] = a[i];
    return s;
  endfunction

  function automatic logic [FM-1:0] ref_mul(input logic [FM-1:0] a, input logic [FM-1:0] b);
    logic [FW-1:0] p;
    logic [FW-1:0] ax;
    p  = '0;
    ax = {{(FW-FM){1'b0}}, a};
    for (int i = 0; i < FM; i++) begin
      if (b[i]) p = p ^ (ax << i);
    end
    return ref_reduce(p);
  endfunction

  function automatic logic [FM-1:0] rnd_elem();
    logic [255:0] t;
    for (int k = 0; k < 8; k++) t[k*32 +: 32] = $urandom;
    return t[FM-1:0];
  endfunction

  function automatic logic [FW-1:0] rnd_wide();
    logic [511:0] t;
    for (int k = 0; k < 16; k++) t[k*32 +: 32] = $urandom;
    return t[FW-1:0];
  endfunction

  task automatic chk(input string tag, input logic [FM-1:0] act, input logic [FM-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic [FM-1:0] a, input logic [FW-1:0] w);
    @(negedge clk);
    en = 1'b1; mode = m; a_in = a; wide_in = w;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FM-1:0] a, b, sa, sb, held;
    logic [FW-1:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; a_in = '0; wide_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset res", res_out, '0);
    chk_bit("R1 reset vld", vld_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release res", res_out, '0);
    chk_bit("R1 after release vld", vld_out, 1'b0);

    // R2 directed squares
    run(1'b0, '0, '0);                 chk("R2 zero", res_out, '0);
    chk_bit("R5 vld after en", vld_out, 1'b1);
    run(1'b0, {{(FM-1){1'b0}},1'b1}, '0); chk("R2 one", res_out, {{(FM-1){1'b0}},1'b1});
    a = '0; a[FM-1] = 1'b1;
    run(1'b0, a, '0);                  chk("R2 x^232", res_out, ref_reduce(ref_spread(a)));
    a = '1;
    run(1'b0, a, '0);                  chk("R2 all ones", res_out, ref_reduce(ref_spread(a)));

    // R3 directed reductions
    w = '0; w[FW-1] = 1'b1;
    run(1'b1, '0, w);                  chk("R3 x^464", res_out, ref_reduce(w));
    w = '1;
    run(1'b1, '0, w);                  chk("R3 all ones", res_out, ref_reduce(w));
    w = '0; w[FM] = 1'b1;
    run(1'b1, '0, w);                  chk("R3 x^233", res_out, ref_reduce(w));

    // R8 short input passes unchanged
    a = rnd_elem(); w = '0; w[FM-1:0] = a;
    run(1'b1, '1, w);                  chk("R8 short passthru", res_out, a);

    // R4 hold and R5 valid drop
    held = res_out;
    @(negedge clk);
    mode = 1'b0; a_in = rnd_elem(); wide_in = rnd_wide();
    @(negedge clk);
    chk("R4 hold", res_out, held);
    chk_bit("R5 vld low", vld_out, 1'b0);

    // R7 unselected input ignored
    a = rnd_elem();
    run(1'b0, a, rnd_wide());          sa = res_out;
    run(1'b0, a, rnd_wide());          chk("R7 wide ignored in square", res_out, sa);
    w = rnd_wide();
    run(1'b1, rnd_elem(), w);          sa = res_out;
    run(1'b1, rnd_elem(), w);          chk("R7 a ignored in reduce", res_out, sa);

    // R6 linearity
    a = rnd_elem(); b = rnd_elem();
    run(1'b0, a, '0); sa = res_out;
    run(1'b0, b, '0); sb = res_out;
    run(1'b0, a ^ b, '0);              chk("R6 linear", res_out, sa ^ sb);

    // random mix
    for (int n = 0; n < 40; n++) begin
      a = rnd_elem();
      run(1'b0, a, rnd_wide());
      chk("R2 random square", res_out, ref_reduce(ref_spread(a)));
      chk("R6 square vs product", res_out, ref_mul(a, a));
      w = rnd_wide();
      run(1'b1, rnd_elem(), w);
      chk("R3 random reduce", res_out, ref_reduce(w));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule